// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operands

This block is the combinational execute stage of a small load-store processor working on 32-bit words. Each cycle it receives two register values, a 16-bit constant field, a 5-bit shift count and a 4-bit operation code. It returns one 32-bit result from that single set of inputs. It covers register-to-register add and subtract, bitwise AND, OR, NOR and XOR, zero-filling logical shifts in both directions, the constant forms of add, AND, OR and XOR, and a load of the constant into the upper half of the word.

The unit decides inside itself which second operand an operation uses. The add constant is sign-extended to a full word. The logical constants are zero-extended. The block keeps no state and raises no flags. Decoding of raw instruction words, the register file, memory and branch logic all sit outside it. A full 32-bit constant is built in two steps: an upper-half load, whose result is fed back as the first operand of an OR with the low half.

Top module: `alu_exec`

## Requirements
- R1: Code 0 (ADD) returns src_a_i + src_b_i modulo 2^32, with no overflow indication.
- R2: Code 1 (SUB) returns src_a_i - src_b_i modulo 2^32; swapping the operands changes the result.
- R3: Code 2 (SLL) returns src_a_i shifted left by shamt_i (0 to 31); vacated low bits are zero.
- R4: Code 3 (SRL) returns src_a_i shifted right by shamt_i (0 to 31); vacated high bits are zero.
- R5: Codes 4, 5, 6 and 7 return the bitwise AND, OR, NOR and XOR of src_a_i and src_b_i over all 32 bits.
- R6: Code 8 (ADDI) returns src_a_i plus imm_i sign-extended from bit 15, so 0x8000 adds -32768 and 0x7FFF adds 32767.
- R7: Codes 9, 10 and 11 (ANDI, ORI, XORI) combine src_a_i with imm_i zero-extended to 32 bits.
- R8: Code 12 (LUI) returns imm_i in bits 31:16 and zero in bits 15:0.
- R9: Feeding the LUI result as src_a_i of an ORI with the low half yields the full 32-bit constant {upper, lower}.
- R10: Codes 13, 14 and 15 return zero.
- R11: Register-register operations ignore imm_i. Immediate operations and shifts ignore src_b_i. Only the shifts use shamt_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 32 | First source register value |
| src_b_i | input | 32 | Second source register value |
| imm_i | input | 16 | Constant field of the instruction |
| shamt_i | input | 5 | Constant shift count |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |

## Verification
The embedded checks assume that every input port carries a known 0 or 1 value whenever it is evaluated. The block has no reset to mask unknowns. The bench therefore gives every input a defined value at declaration and only ever drives full, known words. The operation code is drawn across all sixteen values, including the three unused codes. Operands are mixed randomly with the corner values: all-ones, 0x8000 and 0x7FFF constants, and shift counts of 0 and 31. This keeps every decoded path inside the assumed conditions.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NOR  = 4'd6,
    OP_XOR  = 4'd7,
    OP_ADDI = 4'd8,
    OP_ANDI = 4'd9,
    OP_ORI  = 4'd10,
    OP_XORI = 4'd11,
    OP_LUI  = 4'd12,
    OP_RSV0 = 4'd13,
    OP_RSV1 = 4'd14,
    OP_RSV2 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext, imm_zext;
  assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zext = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    unique case (op_i)
      OP_ADDI:                  opnd_b_o = imm_sext;
      OP_ANDI, OP_ORI, OP_XORI: opnd_b_o = imm_zext;
      default:                  opnd_b_o = src_b_i;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADDI) begin
      // R6: upper part replicates the constant's sign
      a_r6_sign_ext: assert ((opnd_b_o[DATA_W-1:IMM_W-1] == '0 ||
                              opnd_b_o[DATA_W-1:IMM_W-1] == '1) &&
                             opnd_b_o[IMM_W-1:0] == imm_i)
        else $error("addi operand not sign extended");
    end
    if (op_i inside {OP_ANDI, OP_ORI, OP_XORI}) begin
      a_r7_zero_ext: assert (opnd_b_o[DATA_W-1:IMM_W] == '0 && opnd_b_o[IMM_W-1:0] == imm_i)
        else $error("logical constant not zero extended");
    end
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] b_inv;
  assign b_inv = sub_i ? ~b_i : b_i;
  // carry-in of one completes two's complement negation; wraps silently
  assign sum_o = a_i + b_inv + {{(DATA_W-1){1'b0}}, sub_i};

  always_comb begin
    if (sub_i) begin
      a_r2_sub_inverse: assert (DATA_W'(sum_o + b_i) == a_i)
        else $error("difference plus subtrahend differs from minuend");
    end else begin
      a_r1_add_inverse: assert (DATA_W'(sum_o - b_i) == a_i)
        else $error("sum minus addend differs from first operand");
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int  DATA_W  = 32,
  parameter int  SHAMT_W = 5,
  parameter bit  LEFT    = 1'b1
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  assign stage[0] = a_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    if (LEFT) begin : g_left
      assign stage[s+1] = shamt_i[s] ? {stage[s][DATA_W-1-DIST:0], {DIST{1'b0}}} : stage[s];
    end else begin : g_right
      assign stage[s+1] = shamt_i[s] ? {{DIST{1'b0}}, stage[s][DATA_W-1:DIST]} : stage[s];
    end
  end

  assign res_o = stage[SHAMT_W];

  always_comb begin
    if (shamt_i == '0) begin
      a_r3_zero_shift: assert (res_o == a_i) else $error("zero shift altered word");
    end
    if (shamt_i == SHAMT_W'(DATA_W-1)) begin
      if (LEFT) begin
        a_r3_full_left: assert (res_o == {a_i[0], {(DATA_W-1){1'b0}}})
          else $error("max left shift wrong");
      end else begin
        a_r4_full_right: assert (res_o == {{(DATA_W-1){1'b0}}, a_i[DATA_W-1]})
          else $error("max right shift wrong");
      end
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o,
  output logic [DATA_W-1:0] xor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~or_o;
  assign xor_o = a_i ^ b_i;

  always_comb begin
    a_r5_and_nor_disjoint: assert ((and_o & nor_o) == '0)
      else $error("and and nor overlap");
    a_r5_xor_partition: assert ((and_o ^ xor_o) == or_o)
      else $error("xor and and do not partition or");
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  src_a_i,
  input  logic [DATA_W-1:0]  src_b_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [3:0]         op_i,
  output logic [DATA_W-1:0]  result_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] opnd_b, sum, shl, shr, and_r, or_r, nor_r, xor_r, lui_r;
  logic              is_sub;

  alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd_sel (
    .op_i(op), .src_b_i(src_b_i), .imm_i(imm_i), .opnd_b_o(opnd_b)
  );

  assign is_sub = (op == OP_SUB);

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(src_a_i), .b_i(opnd_b), .sub_i(is_sub), .sum_o(sum)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_shl (
    .a_i(src_a_i), .shamt_i(shamt_i), .res_o(shl)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_shr (
    .a_i(src_a_i), .shamt_i(shamt_i), .res_o(shr)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(src_a_i), .b_i(opnd_b),
    .and_o(and_r), .or_o(or_r), .nor_o(nor_r), .xor_o(xor_r)
  );

  assign lui_r = {imm_i, {LOW_W{1'b0}}};

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDI: result_o = sum;
      OP_SLL:                  result_o = shl;
      OP_SRL:                  result_o = shr;
      OP_AND, OP_ANDI:         result_o = and_r;
      OP_OR, OP_ORI:           result_o = or_r;
      OP_NOR:                  result_o = nor_r;
      OP_XOR, OP_XORI:         result_o = xor_r;
      OP_LUI:                  result_o = lui_r;
      default:                 result_o = '0;
    endcase
  end

  always_comb begin
    if (op == OP_LUI) begin
      a_r8_lui_layout: assert (result_o[LOW_W-1:0] == '0 && result_o[DATA_W-1:LOW_W] == imm_i)
        else $error("upper load layout wrong");
    end
    if (op inside {OP_RSV0, OP_RSV1, OP_RSV2}) begin
      a_r10_unused_zero: assert (result_o == '0) else $error("unused code gave nonzero");
    end
    if (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR, OP_XOR}) begin
      a_r11_reg_operand: assert (opnd_b == src_b_i) else $error("register op used constant");
    end
  end
endmodule

// File: tb/alu_exec_bench.sv
module alu_exec_bench;
  logic        clk = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  op = '0;
  logic [31:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_exec u_alu_exec (
    .src_a_i(src_a), .src_b_i(src_b), .imm_i(imm), .shamt_i(shamt),
    .op_i(op), .result_o(result)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] k,
                                        input logic [4:0] s);
    int signed kv;
    kv = int'($signed(k));
    case (o)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a << s;
      4'd3:  return a >> s;
      4'd4:  return a & b;
      4'd5:  return a | b;
      4'd6:  return ~(a | b);
      4'd7:  return a ^ b;
      4'd8:  return a + 32'(kv);
      4'd9:  return a & 32'(k);
      4'd10: return a | 32'(k);
      4'd11: return a ^ 32'(k);
      4'd12: return 32'(k) << 16;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] k, input logic [4:0] s);
    @(posedge clk); #1;
    op = o; src_a = a; src_b = b; imm = k; shamt = s;
  endtask

  task automatic expect_val(input logic [31:0] exp, input string req);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d got=%h exp=%h", req, op, result, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] k, input logic [4:0] s, input string req);
    apply(o, a, b, k, s);
    expect_val(model(o, a, b, k, s), req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] up;
    expect_val(32'd0, "R1 idle add of zeros");
    run(4'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, "R1 add wrap");
    run(4'd0, 32'h1234_5678, 32'h1111_1111, 16'hFFFF, 5'd7, "R1 add");
    run(4'd1, 32'd5, 32'd9, 16'h0, 5'd0, "R2 sub order a-b");
    run(4'd1, 32'd9, 32'd5, 16'h0, 5'd0, "R2 sub order swapped");
    run(4'd2, 32'h8000_0001, 32'hFFFF_FFFF, 16'h0, 5'd0, "R3 sll by 0");
    run(4'd2, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd31, "R3 sll by 31");
    run(4'd3, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd31, "R4 srl by 31");
    run(4'd3, 32'h8000_0000, 32'h0, 16'h0, 5'd4, "R4 srl zero fill");
    run(4'd4, 32'hFFFF_FFFF, 32'h0F0F_00FF, 16'h0, 5'd0, "R5 and");
    run(4'd5, 32'hF000_0000, 32'h0000_000F, 16'h0, 5'd0, "R5 or");
    run(4'd6, 32'h0, 32'h0, 16'h0, 5'd0, "R5 nor of zeros");
    run(4'd7, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 16'h0, 5'd0, "R5 xor all ones");
    run(4'd8, 32'd0, 32'h0, 16'h8000, 5'd0, "R6 addi 0x8000");
    expect_val(32'hFFFF_8000, "R6 addi 0x8000 literal");
    run(4'd8, 32'd1, 32'h0, 16'h7FFF, 5'd0, "R6 addi 0x7FFF");
    expect_val(32'h0000_8000, "R6 addi 0x7FFF literal");
    run(4'd9, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, "R7 andi zero ext");
    expect_val(32'h0000_8000, "R7 andi literal");
    run(4'd10, 32'h0, 32'h0, 16'hFFFF, 5'd0, "R7 ori");
    run(4'd11, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, "R7 xori");
    expect_val(32'hFFFF_0000, "R7 xori literal");
    run(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hAAAA, 5'd9, "R8 lui");
    expect_val(32'hAAAA_0000, "R8 lui literal");
    up = result;
    run(4'd10, up, 32'h0, 16'hF0F0, 5'd0, "R9 lui then ori");
    expect_val(32'hAAAA_F0F0, "R9 chained constant");
    for (int c = 13; c < 16; c++)
      run(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, "R10 unused code");
    apply(4'd0, 32'd10, 32'd20, 16'h1234, 5'd3);
    expect_val(32'd30, "R11 add ignores imm and shamt");
    apply(4'd8, 32'd10, 32'hDEAD_BEEF, 16'h0005, 5'd0);
    expect_val(32'd15, "R11 addi ignores src_b");
    apply(4'd2, 32'd1, 32'hFFFF_FFFF, 16'hFFFF, 5'd4);
    expect_val(32'd16, "R11 sll ignores src_b and imm");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = (i % 7 == 0) ? 32'hFFFF_FFFF : $urandom;
      rb = (i % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
      run(4'($urandom_range(0, 15)), ra, rb, 16'($urandom), 5'($urandom), "R1 random sweep all ops");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule